// File: doc/BRIEF.md
# In-memory bulk copy command sequencer

This block sits inside a memory controller and turns a request to copy one DRAM row onto another, or to clear a row, into a timed stream of ordinary channel commands. Each request names a source bank and row, a destination bank and row, a byte length and a zero flag. The block decides how the request can be served. When both rows sit in the same bank and subarray, it uses a double activation: the source row is opened, the destination row is opened over the still-latched sense amplifiers, and the bank is then closed. When the rows sit in different banks or subarrays, it opens both rows and moves the row one 64-byte column at a time with paired reads and writes. A request that does not cover exactly one whole row is handed back for an ordinary software copy.

Before any command goes out, the block asks the cache to flush and invalidate the lines behind both rows, and it waits for an acknowledge. A clear request is carried out as a copy from a reserved all-zero row. That row is the lowest row of the destination's subarray. Every command waits for a programmable gap after the previous one. A stall input holds back issue, for example while refresh runs. A one-cycle done pulse carries a status code that says which path was taken. Only one request is in flight at a time.

Top module: `bulk_copy_seq`

## Requirements
- R1: If source and destination share a bank and subarray, the commands are ACTIVATE source row, ACTIVATE destination row, then PRECHARGE of the destination bank and row, with no PRECHARGE between the two ACTIVATEs, and done_status is 1 (fast).
- R2: If the banks differ or the subarrays differ, the commands are ACTIVATE source, ACTIVATE destination, then for each column c from 0 up to COLS-1 a READ of source column c followed by a WRITE of destination column c, then PRECHARGE source and PRECHARGE destination, and done_status is 2 (serial). COLS is ROW_BYTES/64.
- R3: A request whose length is not ROW_BYTES raises no flush and issues no command, and done pulses in the cycle after acceptance with done_status 3 (fallback).
- R4: For an accelerated request, flush_req is high from the cycle after acceptance through the cycle in which flush_ack is seen high. flush_req carries the effective source and the destination addresses, and no command is issued while it is high.
- R5: With req_zero set, the source fields given are ignored. The source becomes the destination bank, with a row whose subarray bits equal the destination's and whose other bits are zero, and the request always takes the fast path.
- R6: cmd_op encodes ACTIVATE as 0, PRECHARGE as 1, READ as 2 and WRITE as 3. cmd_col is 0 for ACTIVATE and PRECHARGE.
- R7: After a command issued in cycle t with gap g, the next command, or done after the last PRECHARGE, comes no earlier than cycle t+max(g,1). The gap is t_rcd after the first ACTIVATE, t_ras (fast) or t_rcd (serial) after the second ACTIVATE, t_rtw after a READ, 0 after a WRITE other than the last, t_ras after the last WRITE, 0 after the source PRECHARGE and t_rp after the final PRECHARGE.
- R8: A command is issued in the first cycle in which its gap has elapsed and cmd_stall is low. The first command can go out in the cycle after the acknowledge.
- R9: While cmd_stall is high, no command is issued, and the gap counters keep running.
- R10: done is a single-cycle pulse, and done_status is 0 in every cycle without done.
- R11: req_ready is high only while no request is in flight. It is low from the cycle after acceptance through the done cycle.
- R12: The subarray of a row is its top SA_W row-address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_zero | input | 1 | Clear the destination row instead of copying |
| req_src_bank | input | BANK_W | Source bank |
| req_src_row | input | ROW_W | Source row |
| req_dst_bank | input | BANK_W | Destination bank |
| req_dst_row | input | ROW_W | Destination row |
| req_len | input | LEN_W | Length in bytes |
| flush_req | output | 1 | Flush and invalidate request to the cache |
| flush_ack | input | 1 | Flush completed |
| flush_src_bank | output | BANK_W | Effective source bank to flush |
| flush_src_row | output | ROW_W | Effective source row to flush |
| flush_dst_bank | output | BANK_W | Destination bank to flush |
| flush_dst_row | output | ROW_W | Destination row to flush |
| t_rcd | input | TW | Gap after an opening ACTIVATE, in cycles |
| t_ras | input | TW | Gap before closing an opened row, in cycles |
| t_rp | input | TW | Gap after the final PRECHARGE, in cycles |
| t_rtw | input | TW | Gap from READ to WRITE, in cycles |
| cmd_stall | input | 1 | Hold back command issue |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |
| done | output | 1 | Request finished |
| done_status | output | 2 | 1 fast, 2 serial, 3 fallback |

## Verification
The bench builds the block with 512-byte rows, 8-bit rows split into four subarrays and four banks. With these values a serial copy is only eight read/write pairs, so the column counter wrapping at the last column is reached many times. The subarray boundary between rows 0x3F and 0x40 is also easy to reach with a chosen address. Gap values of 0, 1 and larger are swept, together with acknowledge delays of zero and several cycles, random stalls and back-to-back requests. This covers the max(g,1) rule and the first-issue cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_PRE = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_NONE     = 2'd0,
    ST_FAST     = 2'd1,
    ST_SERIAL   = 2'd2,
    ST_FALLBACK = 2'd3
  } stat_e;
endpackage

// File: rtl/bcs_classify.sv
module bcs_classify
  import bcs_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 12,
  parameter int SA_W      = 3,
  parameter int LEN_W     = 16,
  parameter int ROW_BYTES = 4096
) (
  input  logic              zero,
  input  logic [BANK_W-1:0] src_bank,
  input  logic [ROW_W-1:0]  src_row,
  input  logic [BANK_W-1:0] dst_bank,
  input  logic [ROW_W-1:0]  dst_row,
  input  logic [LEN_W-1:0]  len,
  output stat_e             mode,
  output logic [BANK_W-1:0] eff_bank,
  output logic [ROW_W-1:0]  eff_row
);
  localparam int LOW_W = ROW_W - SA_W;

  function automatic logic [SA_W-1:0] sa_of(input logic [ROW_W-1:0] r);
    return r[ROW_W-1 -: SA_W];
  endfunction

  function automatic logic [ROW_W-1:0] zero_row_of(input logic [ROW_W-1:0] r);
    return {sa_of(r), {LOW_W{1'b0}}};
  endfunction

  logic whole_row, same_sa;

  always_comb begin
    eff_bank  = zero ? dst_bank : src_bank;
    eff_row   = zero ? zero_row_of(dst_row) : src_row;
    whole_row = (len == LEN_W'(ROW_BYTES));
    same_sa   = (eff_bank == dst_bank) && (sa_of(eff_row) == sa_of(dst_row));
    if (!whole_row)   mode = ST_FALLBACK;
    else if (same_sa) mode = ST_FAST;
    else              mode = ST_SERIAL;
  end
endmodule

// File: rtl/bcs_timer.sv
module bcs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [TW-1:0] gap,
  output logic          ready
);
  logic [TW-1:0] cnt;

  assign ready = (cnt <= TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (load)       cnt <= gap;
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  AST_LOAD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ready);  // R7
endmodule

// File: rtl/bulk_copy_seq.sv
module bulk_copy_seq
  import bcs_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 12,
  parameter int SA_W      = 3,
  parameter int LEN_W     = 16,
  parameter int ROW_BYTES = 4096,
  parameter int TW        = 8,
  localparam int COLS     = ROW_BYTES / 64,
  localparam int COL_W    = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_zero,
  input  logic [BANK_W-1:0] req_src_bank,
  input  logic [ROW_W-1:0]  req_src_row,
  input  logic [BANK_W-1:0] req_dst_bank,
  input  logic [ROW_W-1:0]  req_dst_row,
  input  logic [LEN_W-1:0]  req_len,
  output logic              flush_req,
  input  logic              flush_ack,
  output logic [BANK_W-1:0] flush_src_bank,
  output logic [ROW_W-1:0]  flush_src_row,
  output logic [BANK_W-1:0] flush_dst_bank,
  output logic [ROW_W-1:0]  flush_dst_row,
  input  logic [TW-1:0]     t_rcd,
  input  logic [TW-1:0]     t_ras,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_rtw,
  input  logic              cmd_stall,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              done,
  output logic [1:0]        done_status
);
  typedef enum logic [3:0] {
    S_IDLE, S_FLUSH, S_ACT_S, S_ACT_D, S_RD, S_WR, S_PRE_S, S_PRE_D, S_FIN
  } state_e;

  state_e            state, nxt;
  stat_e             mode_q, cls_mode;
  logic [BANK_W-1:0] sb_q, db_q, cls_bank;
  logic [ROW_W-1:0]  sr_q, dr_q, cls_row;
  logic [COL_W-1:0]  col_q;
  logic              accept, fire, is_cmd, tmr_ready, tmr_clear, last_col;
  op_e               c_op;
  logic [TW-1:0]     c_gap;

  bcs_classify #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .SA_W(SA_W), .LEN_W(LEN_W), .ROW_BYTES(ROW_BYTES)
  ) cls_i (
    .zero(req_zero), .src_bank(req_src_bank), .src_row(req_src_row),
    .dst_bank(req_dst_bank), .dst_row(req_dst_row), .len(req_len),
    .mode(cls_mode), .eff_bank(cls_bank), .eff_row(cls_row)
  );

  bcs_timer #(.TW(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .load(fire),
    .gap(c_gap), .ready(tmr_ready)
  );

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign tmr_clear = accept || (state == S_FLUSH && flush_ack);
  assign last_col  = (col_q == COL_W'(COLS - 1));
  assign fire      = is_cmd && tmr_ready && !cmd_stall;

  always_comb begin
    is_cmd   = 1'b1;
    c_op     = OP_ACT;
    cmd_bank = sb_q;
    cmd_row  = sr_q;
    cmd_col  = '0;
    c_gap    = '0;
    nxt      = state;
    case (state)
      S_ACT_S: begin c_gap = t_rcd; nxt = S_ACT_D; end
      S_ACT_D: begin
        cmd_bank = db_q; cmd_row = dr_q;
        c_gap = (mode_q == ST_FAST) ? t_ras : t_rcd;
        nxt   = (mode_q == ST_FAST) ? S_PRE_D : S_RD;
      end
      S_RD: begin c_op = OP_RD; cmd_col = col_q; c_gap = t_rtw; nxt = S_WR; end
      S_WR: begin
        c_op = OP_WR; cmd_bank = db_q; cmd_row = dr_q; cmd_col = col_q;
        c_gap = last_col ? t_ras : '0;
        nxt   = last_col ? S_PRE_S : S_RD;
      end
      S_PRE_S: begin c_op = OP_PRE; nxt = S_PRE_D; end
      S_PRE_D: begin
        c_op = OP_PRE; cmd_bank = db_q; cmd_row = dr_q; c_gap = t_rp; nxt = S_FIN;
      end
      default: is_cmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= ST_NONE;
      sb_q   <= '0; sr_q <= '0; db_q <= '0; dr_q <= '0;
      col_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          mode_q <= cls_mode;
          sb_q   <= cls_bank;     sr_q <= cls_row;
          db_q   <= req_dst_bank; dr_q <= req_dst_row;
          col_q  <= '0;
          state  <= (cls_mode == ST_FALLBACK) ? S_FIN : S_FLUSH;
        end
        S_FLUSH: if (flush_ack) state <= S_ACT_S;
        S_FIN:   if (tmr_ready) state <= S_IDLE;
        default: if (fire) begin
          state <= nxt;
          if (state == S_WR) col_q <= col_q + COL_W'(1);
        end
      endcase
    end
  end

  assign cmd_valid      = fire;
  assign cmd_op         = c_op;
  assign flush_req      = (state == S_FLUSH);
  assign flush_src_bank = sb_q;
  assign flush_src_row  = sr_q;
  assign flush_dst_bank = db_q;
  assign flush_dst_row  = dr_q;
  assign done           = (state == S_FIN) && tmr_ready;
  assign done_status    = done ? mode_q : ST_NONE;

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stall |-> !cmd_valid);  // R9
  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !cmd_valid);  // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_valid && !flush_req && !done));  // R11
  AST_FALLBACK_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls_mode == ST_FALLBACK) |=> (done && done_status == 2'd3));  // R3
endmodule

// File: tb/bulk_copy_seq_tb_top.sv
module bulk_copy_seq_tb_top;
  localparam int BW = 2, RW = 8, SW = 2, LW = 16, RB = 512, TW = 8;
  localparam int COLS = RB / 64, CW = $clog2(COLS);

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 0, req_ready, req_zero = 0;
  logic [BW-1:0] req_src_bank = 0, req_dst_bank = 0;
  logic [RW-1:0] req_src_row = 0, req_dst_row = 0;
  logic [LW-1:0] req_len = 0;
  logic          flush_req, flush_ack = 0;
  logic [BW-1:0] flush_src_bank, flush_dst_bank;
  logic [RW-1:0] flush_src_row, flush_dst_row;
  logic [TW-1:0] t_rcd = 3, t_ras = 5, t_rp = 2, t_rtw = 2;
  logic          cmd_stall = 0, cmd_valid, done;
  logic [1:0]    cmd_op, done_status;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;

  bulk_copy_seq #(.BANK_W(BW), .ROW_W(RW), .SA_W(SW), .LEN_W(LW), .ROW_BYTES(RB), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_zero(req_zero),
    .req_src_bank(req_src_bank), .req_src_row(req_src_row), .req_dst_bank(req_dst_bank),
    .req_dst_row(req_dst_row), .req_len(req_len), .flush_req(flush_req), .flush_ack(flush_ack),
    .flush_src_bank(flush_src_bank), .flush_src_row(flush_src_row),
    .flush_dst_bank(flush_dst_bank), .flush_dst_row(flush_dst_row),
    .t_rcd(t_rcd), .t_ras(t_ras), .t_rp(t_rp), .t_rtw(t_rtw), .cmd_stall(cmd_stall),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .done(done), .done_status(done_status)
  );

  typedef struct { int op; int bank; int row; int col; int gap; } ev_t;
  ev_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  int mphase = 0;            // 0 idle, 1 flush, 2 run, 3 fin
  int ready_at = 0, fl_cnt = 0, exp_stat = 0, ack_delay = 0;
  int esb = 0, esr = 0;
  bit pend = 0, finished = 0, stall_en = 0;
  string tag = "R11";

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", t, what, act, exp, cyc);
    end
  endtask

  function automatic int sa(int r);
    return r >> (RW - SW);
  endfunction

  task automatic push(int op, int b, int r, int c, int g);
    ev_t e;
    e.op = op; e.bank = b; e.row = r; e.col = c; e.gap = g;
    q.push_back(e);
  endtask

  task automatic build();
    q.delete();
    esb = req_zero ? int'(req_dst_bank) : int'(req_src_bank);
    esr = req_zero ? (sa(req_dst_row) << (RW - SW)) : int'(req_src_row);
    if (int'(req_len) != RB) begin
      exp_stat = 3;
    end else if (esb == int'(req_dst_bank) && sa(esr) == sa(req_dst_row)) begin
      exp_stat = 1;
      push(0, esb, esr, 0, t_rcd);
      push(0, req_dst_bank, req_dst_row, 0, t_ras);
      push(1, req_dst_bank, req_dst_row, 0, t_rp);
    end else begin
      exp_stat = 2;
      push(0, esb, esr, 0, t_rcd);
      push(0, req_dst_bank, req_dst_row, 0, t_rcd);
      for (int c = 0; c < COLS; c++) begin
        push(2, esb, esr, c, t_rtw);
        push(3, req_dst_bank, req_dst_row, c, (c == COLS - 1) ? int'(t_ras) : 0);
      end
      push(1, esb, esr, 0, 0);
      push(1, req_dst_bank, req_dst_row, 0, t_rp);
    end
  endtask

  task automatic tick();
    bit ev, ed;
    @(negedge clk);
    req_valid = pend;
    flush_ack = (mphase == 1) && (fl_cnt >= ack_delay);
    cmd_stall = stall_en ? ($urandom_range(0, 2) == 0) : 1'b0;
    #1;
    chk("R11", "req_ready", req_ready, mphase == 0);
    chk("R4", "flush_req", flush_req, mphase == 1);
    ev = (mphase == 2) && (cyc >= ready_at) && !cmd_stall;
    chk(stall_en ? "R9" : "R7 R8", "cmd_valid", cmd_valid, ev);
    ed = (mphase == 3) && (cyc >= ready_at);
    chk("R10", "done", done, ed);
    chk(tag, "done_status", done_status, ed ? exp_stat : 0);
    case (mphase)
      0: if (pend) begin
        build();
        pend = 0;
        if (exp_stat == 3) begin mphase = 3; ready_at = cyc + 1; end
        else begin mphase = 1; fl_cnt = 0; end
      end
      1: begin
        chk(tag, "flush_src_bank", flush_src_bank, esb);
        chk(tag, "flush_src_row", flush_src_row, esr);
        chk("R4", "flush_dst_row", flush_dst_row, req_dst_row);
        if (flush_ack) begin mphase = 2; ready_at = cyc + 1; end
        else fl_cnt++;
      end
      2: if (ev && q.size() > 0) begin
        ev_t e = q.pop_front();
        chk("R6", "cmd_op", cmd_op, e.op);
        chk(tag, "cmd_bank", cmd_bank, e.bank);
        chk(tag, "cmd_row", cmd_row, e.row);
        chk(tag, "cmd_col", cmd_col, e.col);
        ready_at = cyc + ((e.gap == 0) ? 1 : e.gap);
        if (q.size() == 0) mphase = 3;
      end
      default: if (ed) begin mphase = 0; finished = 1; end
    endcase
    cyc++;
  endtask

  task automatic run_req(string t, bit z, int sb, int sr, int db, int dr, int len, int ad, bit st);
    int n = 0;
    tag = t; req_zero = z; req_src_bank = BW'(sb); req_src_row = RW'(sr);
    req_dst_bank = BW'(db); req_dst_row = RW'(dr); req_len = LW'(len);
    ack_delay = ad; stall_en = st; pend = 1; finished = 0;
    while (!finished && n < 3000) begin tick(); n++; end
    if (!finished) begin
      errors++; checks++;
      $display("FAIL %s watchdog actual 0 expected 1", t);
    end
    stall_en = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(); tick();                                    // reset state, R11 R10
    run_req("R1", 0, 1, 8'h12, 1, 8'h2A, RB, 2, 0);    // fast
    run_req("R2", 0, 0, 8'h10, 3, 8'hC4, RB, 1, 0);    // serial, other bank
    run_req("R12", 0, 2, 8'h3F, 2, 8'h40, RB, 0, 0);   // subarray boundary: serial
    run_req("R12", 0, 2, 8'h40, 2, 8'h7F, RB, 0, 0);   // same subarray: fast
    run_req("R5", 1, 3, 8'hFF, 1, 8'hB7, RB, 3, 0);    // zero: src ignored
    run_req("R3", 0, 0, 8'h01, 1, 8'h02, RB / 2, 0, 0);
    run_req("R3", 0, 0, 8'h01, 0, 8'h02, 0, 0, 0);
    run_req("R9", 0, 1, 8'h05, 2, 8'h06, RB, 2, 1);    // serial with stalls
    run_req("R9", 0, 0, 8'h81, 0, 8'h9C, RB, 1, 1);    // fast with stalls
    t_rcd = 0; t_ras = 0; t_rp = 0; t_rtw = 0;
    run_req("R7", 0, 1, 8'h00, 0, 8'hFF, RB, 0, 0);
    run_req("R7", 1, 0, 8'h00, 2, 8'h55, RB, 0, 0);
    t_rcd = 1; t_ras = 1; t_rp = 1; t_rtw = 1;
    run_req("R7", 0, 3, 8'hC0, 3, 8'h80, RB, 4, 0);
    t_rcd = 6; t_ras = 9; t_rp = 4; t_rtw = 3;
    run_req("R8", 0, 2, 8'h44, 1, 8'h44, RB, 0, 0);
    run_req("R5", 1, 0, 8'h00, 3, 8'h3A, RB, 0, 0);
    run_req("R3", 1, 0, 8'h00, 3, 8'h3A, RB + 64, 0, 0);
    tick(); tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule